// File: doc/BRIEF.md
# Cascadable LCD Backplane Phase Sequencer

This block produces the backplane phase sequence for a multiplexed segment LCD driver. On every clock it moves one active backplane output forward. The number of phases in a frame comes from a mode input: one phase (static drive), two, three or four. Exactly one backplane output is high at any time. When the counter passes the last phase of the current mode, it wraps back to the first backplane.

Several copies of the block can drive one panel. They share one open-drain line with a pull-up, which acts as a wired-AND. Each copy pulls the line low for the whole of its last active phase and leaves it released at all other times. Each copy also watches the line through a synchronizer. When another copy makes the line fall, the receiver loads the phase the asserting copy has reached by then, allowing for the synchronizer delay. From then on both copies step together. The block filters out the echo of its own drive. A line held low counts as one event. Copies released from reset in the same cycle stay aligned without any correction.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: Exactly one bit of `bp_out` is high in every cycle. Bit i is high when backplane phase i is active, and bit 0 is the first backplane.
- R2: `mux_mode` holds the index of the last active phase. 0 = static (one phase), 1 = two phases, 2 = three phases, 3 = four phases. While the mode is unchanged, no bit above `mux_mode` is ever high.
- R3: With no foreign event, the phase advances by one every clock. After the last phase of the mode it returns to phase 0.
- R4: `sync_drive_low` is high exactly in the cycles where the last active phase is on `bp_out`. In modes 1 to 3 this gives a one-cycle pulse per frame. In static mode the line stays driven low.
- R5: While `rst_n` is low, the phase is cleared to 0 and the line drive is released. The first cycle after reset shows `bp_out` = 0001 with `sync_drive_low` low.
- R6: A falling edge on `sync_in` that this instance did not cause is detected two stages after a synchronizer. Suppose the line first reads low in cycle t. Then in cycle t+3 the phase is (2 mod phase count), which is the phase the asserting instance has reached.
- R7: A falling edge caused by this instance's own drive never changes its phase sequence.
- R8: A line held low for many cycles causes one realignment only. After that, the phase keeps stepping as in R3.
- R9: If the mode changes while the phase index is at or above the new last index, the next phase is 0.
- R10: Two instances on one shared line, released from reset in the same cycle, show the same `bp_out` and `sync_drive_low` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-phase clock; one backplane phase per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_mode | input | $clog2(MAX_BP) | Index of the last active phase (0 = static) |
| bp_out | output | MAX_BP | One-hot active backplane |
| sync_drive_low | output | 1 | Enable for the open-drain pull-down of the shared line |
| sync_in | input | 1 | Sampled level of the shared line (asynchronous) |

## Verification
The bench uses the default MAX_BP = 4 and SYNC_STAGES = 2, so all four modes are reachable. With two stages, the realign target is phase 0 in the one- and two-phase modes and phase 2 in the three- and four-phase modes. This lets a missing or wrong latency correction show up as a visible phase error. Two instances share a modelled wired-AND line, together with a bench-side pull-down. This makes the echo of each copy's own drive, external single-cycle pulses, held-low lines and mid-frame mode changes all meet in the same run.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;

    parameter int unsigned DEF_MAX_BP      = 4;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_TWO    = 2'd1,
        MUX_THREE  = 2'd2,
        MUX_FOUR   = 2'd3
    } mux_mode_e;

endpackage

// File: rtl/lcd_sync_rx.sv
module lcd_sync_rx #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_line,
    input  logic own_drive,
    output logic foreign_evt
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic [STAGES-1:0] own;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      synced;

    assign synced = st_q.chain[STAGES-1];

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], sync_line};
        st_d.prev  = synced;
        st_d.own   = {st_q.own[STAGES-2:0], own_drive};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.chain <= '1;
            st_q.prev  <= 1'b1;
            st_q.own   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A fall counts only if this instance's own drive, delayed to the same
    // stage, was not the cause.
    assign foreign_evt = st_q.prev & ~synced & ~st_q.own[STAGES-1];

endmodule

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl #(
    parameter int unsigned MAX_BP = 4,
    parameter int unsigned STAGES = 2,
    localparam int unsigned PH_W  = $clog2(MAX_BP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] mode,
    input  logic            realign,
    output logic [PH_W-1:0] phase,
    output logic            drive_low
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            drive;
    } ph_state_t;

    ph_state_t       st_d, st_q;
    logic [PH_W-1:0] last_idx;
    logic [PH_W-1:0] tgt_tbl [MAX_BP];

    generate
        if (MAX_BP == (1 << PH_W)) begin : g_full_range
            assign last_idx = mode;
        end else begin : g_clamped
            assign last_idx = (mode > PH_W'(MAX_BP - 1)) ? PH_W'(MAX_BP - 1) : mode;
        end
    endgenerate

    // Phase reached by the asserting instance, one cycle after detection.
    for (genvar g = 0; g < MAX_BP; g++) begin : g_target
        assign tgt_tbl[g] = PH_W'(STAGES % (g + 1));
    end

    always_comb begin
        st_d = st_q;
        if (realign) begin
            st_d.phase = tgt_tbl[last_idx];
        end else if (st_q.phase >= last_idx) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        st_d.drive = (st_d.phase == last_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.drive <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign drive_low = st_q.drive;

endmodule

// File: rtl/lcd_bp_decode.sv
module lcd_bp_decode #(
    parameter int unsigned MAX_BP = 4,
    localparam int unsigned PH_W  = $clog2(MAX_BP)
) (
    input  logic [PH_W-1:0]   phase,
    output logic [MAX_BP-1:0] bp
);

    for (genvar g = 0; g < MAX_BP; g++) begin : g_bp
        assign bp[g] = (phase == PH_W'(g));
    end

endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer #(
    parameter int unsigned MAX_BP      = lcd_bp_pkg::DEF_MAX_BP,
    parameter int unsigned SYNC_STAGES = lcd_bp_pkg::DEF_SYNC_STAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(MAX_BP)-1:0] mux_mode,
    output logic [MAX_BP-1:0]         bp_out,
    output logic                      sync_drive_low,
    input  logic                      sync_in
);

    localparam int unsigned PH_W = $clog2(MAX_BP);

    logic            realign;
    logic [PH_W-1:0] phase;
    logic            drive;

    lcd_sync_rx #(
        .STAGES(SYNC_STAGES)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_line  (sync_in),
        .own_drive  (drive),
        .foreign_evt(realign)
    );

    lcd_phase_ctrl #(
        .MAX_BP(MAX_BP),
        .STAGES(SYNC_STAGES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mux_mode),
        .realign  (realign),
        .phase    (phase),
        .drive_low(drive)
    );

    lcd_bp_decode #(
        .MAX_BP(MAX_BP)
    ) u_dec (
        .phase(phase),
        .bp   (bp_out)
    );

    assign sync_drive_low = drive;

endmodule

// File: rtl/lcd_bp_sequencer_chk.sv
module lcd_bp_sequencer_chk #(
    parameter int unsigned MAX_BP = 4,
    localparam int unsigned PH_W  = $clog2(MAX_BP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   mux_mode,
    input logic [MAX_BP-1:0] bp_out,
    input logic              sync_drive_low
);

    function automatic logic above_clear(logic [MAX_BP-1:0] bp, logic [PH_W-1:0] m);
        for (int i = 0; i < MAX_BP; i++) begin
            if (i > int'(m) && bp[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bp_out) == 1);

    p_unused_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mux_mode) |-> above_clear(bp_out, mux_mode));

    p_drive_in_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_drive_low && $stable(mux_mode)) |-> bp_out[mux_mode]);

    p_static_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode == '0 && $stable(mux_mode) && $past(rst_n)) |-> sync_drive_low);

    p_reset_state_r5: assert property (@(posedge clk)
        $rose(rst_n) |-> (bp_out == MAX_BP'(1) && !sync_drive_low));

endmodule

bind lcd_bp_sequencer lcd_bp_sequencer_chk #(
    .MAX_BP(MAX_BP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mux_mode      (mux_mode),
    .bp_out        (bp_out),
    .sync_drive_low(sync_drive_low)
);

// File: tb/sim_lcd_bp_sequencer.sv
module sim_lcd_bp_sequencer;
    import lcd_bp_pkg::*;

    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       ext_low;
    logic [3:0] bp0, bp1;
    logic       drv0, drv1;
    logic       line;

    always #4 clk = ~clk;

    assign line = ~(drv0 | drv1 | ext_low);

    lcd_bp_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .mux_mode(mode),
        .bp_out(bp0), .sync_drive_low(drv0), .sync_in(line)
    );

    lcd_bp_sequencer u1 (
        .clk(clk), .rst_n(rst_n), .mux_mode(mode),
        .bp_out(bp1), .sync_drive_low(drv1), .sync_in(line)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference model of one instance; both instances drive identically.
    int     m_ph;
    bit     m_drv;
    bit [1:0] m_ch;
    bit     m_prev;
    bit [1:0] m_own;

    always @(posedge clk) begin : ref_model
        int n;
        int nph;
        bit evt;
        bit ln;
        if (!rst_n) begin
            m_ph = 0; m_drv = 0; m_ch = 2'b11; m_prev = 1; m_own = 2'b00;
        end else begin
            n   = int'(mode) + 1;
            evt = m_prev & ~m_ch[1] & ~m_own[1];
            ln  = ~(m_drv | ext_low);
            if (evt) nph = STG % n;
            else if (m_ph >= int'(mode)) nph = 0;
            else nph = m_ph + 1;
            m_prev = m_ch[1];
            m_ch   = {m_ch[0], ln};
            m_own  = {m_own[0], m_drv};
            m_ph   = nph;
            m_drv  = (nph == int'(mode));
        end
    end

    function automatic logic [3:0] oh(int p);
        return 4'b0001 << p;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk("R1", $countones(bp0), 1);
            chk("R3", bp0, oh(m_ph));
            chk("R4", drv0, m_drv);
            chk("R10", {bp1, drv1}, {bp0, drv0});
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int burst;
        void'($urandom(32'h5eed_1cd0));
        rst_n = 1'b0; mode = MUX_FOUR; ext_low = 1'b0; burst = 0;
        repeat (3) @(negedge clk);
        chk("R5", bp0, 4'b0001);
        chk("R5", drv0, 0);
        rst_n = 1'b1;
        repeat (6) tick();

        // R7: own drive never disturbs the four-phase cycle
        while (bp0 != 4'b0001) tick();
        for (int k = 0; k < 8; k++) begin
            tick();
            chk("R7", bp0, oh((k + 1) % 4));
        end

        // R6: foreign one-cycle pulse during phase 1
        while (bp0 != 4'b0010) tick();
        ext_low = 1'b1;
        tick();
        ext_low = 1'b0;
        tick();
        tick();
        chk("R6", bp0, 4'b0100);
        repeat (6) tick();

        // R8: line held low in three-phase mode
        mode = MUX_THREE;
        repeat (5) tick();
        while (bp0 != 4'b0010) tick();
        ext_low = 1'b1;
        tick(); tick(); tick();
        chk("R8", bp0, 4'b0100);
        tick();
        chk("R8", bp0, 4'b0001);
        repeat (5) tick();
        ext_low = 1'b0;
        repeat (6) begin
            tick();
            chk("R2", bp0[3], 0);
        end

        // R9: mode shrinks while phase 3 is active
        mode = MUX_FOUR;
        repeat (5) tick();
        while (bp0 != 4'b1000) tick();
        mode = MUX_TWO;
        tick();
        chk("R9", bp0, 4'b0001);
        repeat (6) begin
            tick();
            chk("R2", bp0[3:2], 0);
        end

        // R4: static mode keeps the line driven
        mode = MUX_STATIC;
        repeat (4) tick();
        repeat (4) begin
            tick();
            chk("R4", drv0, 1);
            chk("R2", bp0, 4'b0001);
        end

        // random mode changes and foreign pulses
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 49) == 0) mode = 2'($urandom_range(0, 3));
            if (burst == 0 && $urandom_range(0, 19) == 0) burst = $urandom_range(1, 6);
            ext_low = (burst > 0);
            if (burst > 0) burst--;
            tick();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule